// File: doc/BRIEF.md
# Programmable Eight-Master Bus Arbiter

This block arbitrates a shared PCI-style bus among eight masters: a bridge function and a disk controller inside the chip, the host CPU, and five external masters with active-low request/grant pins. Master indices are fixed: 0 is the bridge, 1 the disk controller, 2 the CPU, and 3 to 7 the external pairs 0 to 4. After reset the arbiter rotates round-robin. A priority register marks any subset of masters as high priority. A per-round served mask still guarantees that every requester is granted once before any master is granted a second time.

A strap pin, sampled while reset is held, selects whether the arbiter runs at all. When the arbiter is disabled it grants nothing and routes the two internal masters' request/grant lines to pass-through pins, so that an outside arbiter can serve them. A select input turns the fifth external pair into a flush request output and a flush acknowledge input. With guaranteed access mode also set, the bridge's request reaches arbitration only after the flush handshake has completed.

The arbitration core is a three-state machine. ST_OFF means disabled, and it is entered from any state when the strap was sampled low. ST_PARK means no grant; it goes to ST_OWN when any request is present. ST_OWN means one grant is held. It returns to ST_PARK when the owner drops its request. On an idle bus with another requester present, it hands off from ST_OWN directly to a new ST_OWN. The flush gate is a second machine. FG_IDLE goes to FG_REQ on a bridge request. FG_REQ goes to FG_PASS on acknowledge, or back to FG_IDLE if the request is withdrawn. FG_PASS goes to FG_IDLE when the bridge request drops. The gate is held in FG_IDLE whenever guaranteed access is not active.

Top module: `bus_arbiter8`

## Requirements
- R1: The enable strap `arb_strap` is sampled while `rst_n` is low. A value of 1 enables the arbiter and 0 disables it, and the choice holds until the next reset.
- R2: When disabled, `cpu_gnt_n` and all `ext_gnt_n` bits stay 1 and `flush_sel` has no effect. `pt_req_n` equals the inverse of `int_req`, and `int_gnt` equals the inverse of `pt_gnt_n`.
- R3: When enabled, `pt_req_n` stays 2'b11 and `int_gnt` carries the arbiter's grants for masters 0 and 1.
- R4: At most one master holds a grant at any time. Outputs show no grant directly after reset.
- R5: A grant goes only to a master whose request was active in the cycle before. From the no-grant state, a request sampled at a clock edge is granted right after that edge.
- R6: While the owner keeps requesting and `bus_idle` is 0, its grant holds. When the owner drops its request, the grant is removed at the next edge, and there is at least one cycle with no grant before the next owner.
- R7: While the owner requests, the grant can move straight to another master only at an edge where `bus_idle` is 1 and some other master requests.
- R8: The search for a winner starts at the index after the last winner and wraps modulo 8. After reset the last winner counts as index 7, so the first search begins at master 0.
- R9: A write with `cfg_we`=1 and `cfg_addr`=8'h80 loads `cfg_wdata` into the priority register, where bit i=1 marks master i as high priority. The register resets to 0, which gives pure round-robin. Writes to any other address are ignored. Among eligible masters, high-priority ones win first.
- R10: A master already granted in the current round is not eligible while any requester not yet granted this round remains, whatever its priority. The round ends when no such requester is left.
- R11: With the arbiter enabled and `flush_sel`=1, master 7 never requests. `ext_gnt_n[4]` becomes the active-low flush request, and `ext_req_n[4]` becomes the active-low flush acknowledge.
- R12: In guaranteed access mode (`gat_mode`=1 with R11 in force), a bridge request asserts flush request one edge later. The bridge competes only after acknowledge has been sampled low. Flush request stays asserted until the bridge drops its request.
- R13: Outside guaranteed access mode, the bridge request goes straight to arbitration as for any other master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_strap | input | 1 | Enable strap, sampled during reset |
| bus_idle | input | 1 | Bus is idle this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration index |
| cfg_wdata | input | 8 | Priority mask write data |
| flush_sel | input | 1 | Fifth external pair used as flush handshake |
| gat_mode | input | 1 | Guaranteed access mode |
| int_req | input | 2 | Internal requests (bit 0 bridge, bit 1 disk), active high |
| int_gnt | output | 2 | Internal grants, active high |
| cpu_req_n | input | 1 | CPU request, active low |
| cpu_gnt_n | output | 1 | CPU grant, active low |
| ext_req_n | input | 5 | External requests, active low; bit 4 is flush acknowledge when R11 holds |
| ext_gnt_n | output | 5 | External grants, active low; bit 4 is flush request when R11 holds |
| pt_req_n | output | 2 | Pass-through of internal requests to an outside arbiter |
| pt_gnt_n | input | 2 | Grants from an outside arbiter |

## Verification
The bench builds the block with its default five external pairs, which gives eight masters, and with the priority index at 8'h80. At this size a full rotation lasts only a few cycles, so random request patterns mixed with priority writes wrap the search pointer and clear the served mask many times. With the flush pair in play, the bench sees the gap between the pins' normal and handshake roles. Separate resets with the strap high and low bring both the arbitrating and the pass-through behaviour within reach.

// File: rtl/arb8_pkg.sv
package arb8_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        FG_IDLE = 2'd0,
        FG_REQ  = 2'd1,
        FG_PASS = 2'd2
    } fg_state_t;

    localparam logic [7:0] PRIO_CFG_INDEX = 8'h80;
endpackage

// File: rtl/arb8_prio_reg.sv
module arb8_prio_reg #(
    parameter int          NM      = 8,
    parameter logic [7:0]  CFG_IDX = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    addr,
    input  logic [NM-1:0] wdata,
    output logic [NM-1:0] hp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp <= '0;
        end else if (we && (addr == CFG_IDX)) begin
            hp <= wdata;
        end
    end
endmodule

// File: rtl/arb8_flush_gate.sv
module arb8_flush_gate
    import arb8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bridge_req,
    input  logic ack,
    output logic flush_req,
    output logic fwd_req
);
    fg_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FG_IDLE: if (bridge_req) state_d = FG_REQ;
            FG_REQ: begin
                if (!bridge_req) state_d = FG_IDLE;
                else if (ack)    state_d = FG_PASS;
            end
            FG_PASS: if (!bridge_req) state_d = FG_IDLE;
            default: state_d = FG_IDLE;
        endcase
        if (!active) state_d = FG_IDLE;
    end

    always_comb begin
        flush_req = (state_q != FG_IDLE);
        fwd_req   = (state_q == FG_PASS) && bridge_req;
    end
endmodule

// File: rtl/arb8_core.sv
module arb8_core
    import arb8_pkg::*;
#(
    parameter int NM = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bus_idle,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] hp,
    output logic [NM-1:0] gnt
);
    localparam int IW = (NM > 1) ? $clog2(NM) : 1;
    localparam logic [IW-1:0] LAST_INIT = IW'(NM - 1);

    arb_state_t    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] last_q, last_d;
    logic [NM-1:0] served_q, served_d;

    logic [NM-1:0] pend, base, keep, hi, own_mask;
    logic [IW-1:0] win;
    logic          take;

    function automatic logic [IW-1:0] rr_pick(input logic [NM-1:0] cand,
                                              input logic [IW-1:0] from);
        logic [IW-1:0] res;
        logic          found;
        res   = from;
        found = 1'b0;
        for (int k = 1; k <= NM; k++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(from) + k) % NM);
            if (!found && cand[idx]) begin
                res   = idx;
                found = 1'b1;
            end
        end
        return res;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PARK;
            owner_q  <= '0;
            last_q   <= LAST_INIT;
            served_q <= '0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            last_q   <= last_d;
            served_q <= served_d;
        end
    end

    always_comb begin
        own_mask = NM'(1) << owner_q;
        pend     = req & ~served_q;
        if (pend == '0) begin
            base = req;
            keep = '0;
        end else begin
            base = pend;
            keep = served_q;
        end
        hi  = base & hp;
        win = rr_pick((hi != '0) ? hi : base, last_q);

        state_d  = state_q;
        owner_d  = owner_q;
        last_d   = last_q;
        served_d = served_q;
        take     = 1'b0;

        unique case (state_q)
            ST_OFF: ;
            ST_PARK: if (req != '0) take = 1'b1;
            ST_OWN: begin
                if (!req[owner_q])
                    state_d = ST_PARK;
                else if (bus_idle && ((req & ~own_mask) != '0))
                    take = 1'b1;
            end
            default: state_d = ST_PARK;
        endcase

        if (take) begin
            state_d  = ST_OWN;
            owner_d  = win;
            last_d   = win;
            served_d = keep | (NM'(1) << win);
        end
        if (!en) state_d = ST_OFF;
    end

    always_comb begin
        gnt = (state_q == ST_OWN) ? own_mask : '0;
    end
endmodule

// File: rtl/bus_arbiter8.sv
module bus_arbiter8
    import arb8_pkg::*;
#(
    parameter int N_EXT = 5,
    parameter int NM    = N_EXT + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_strap,
    input  logic             bus_idle,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [NM-1:0]    cfg_wdata,
    input  logic             flush_sel,
    input  logic             gat_mode,
    input  logic [1:0]       int_req,
    output logic [1:0]       int_gnt,
    input  logic             cpu_req_n,
    output logic             cpu_gnt_n,
    input  logic [N_EXT-1:0] ext_req_n,
    output logic [N_EXT-1:0] ext_gnt_n,
    output logic [1:0]       pt_req_n,
    input  logic [1:0]       pt_gnt_n
);
    localparam int EXT_BASE = 3;
    localparam int FL_PAIR  = N_EXT - 1;

    logic          arb_en;
    logic          flush_mode, gat_active;
    logic          flush_req, bridge_fwd;
    logic [NM-1:0] req_vec, gnt_vec, hp_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) arb_en <= arb_strap;
    end

    assign flush_mode = arb_en && flush_sel;
    assign gat_active = flush_mode && gat_mode;

    arb8_prio_reg #(.NM(NM), .CFG_IDX(PRIO_CFG_INDEX)) prio_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .hp    (hp_vec)
    );

    arb8_flush_gate flush_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (gat_active),
        .bridge_req (int_req[0]),
        .ack        (~ext_req_n[FL_PAIR]),
        .flush_req  (flush_req),
        .fwd_req    (bridge_fwd)
    );

    assign req_vec[0] = gat_active ? bridge_fwd : int_req[0];
    assign req_vec[1] = int_req[1];
    assign req_vec[2] = ~cpu_req_n;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        if (g == FL_PAIR) begin : g_flush_pair
            assign req_vec[EXT_BASE+g] = ~ext_req_n[g] & ~flush_mode;
            assign ext_gnt_n[g] = flush_mode ? ~flush_req : ~gnt_vec[EXT_BASE+g];
        end else begin : g_plain_pair
            assign req_vec[EXT_BASE+g] = ~ext_req_n[g];
            assign ext_gnt_n[g] = ~gnt_vec[EXT_BASE+g];
        end
    end

    arb8_core #(.NM(NM)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (arb_en),
        .bus_idle (bus_idle),
        .req      (req_vec),
        .hp       (hp_vec),
        .gnt      (gnt_vec)
    );

    always_comb begin
        cpu_gnt_n = ~gnt_vec[2];
        if (arb_en) begin
            int_gnt  = gnt_vec[1:0];
            pt_req_n = 2'b11;
        end else begin
            int_gnt  = ~pt_gnt_n;
            pt_req_n = ~int_req;
        end
    end
endmodule

// File: rtl/bus_arbiter8_chk.sv
module bus_arbiter8_chk #(
    parameter int N_EXT = 5,
    parameter int NM    = N_EXT + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             bus_idle,
    input logic             gat,
    input logic             flush_req,
    input logic [NM-1:0]    req,
    input logic [NM-1:0]    gnt,
    input logic             cpu_gnt_n,
    input logic [N_EXT-1:0] ext_gnt_n
);
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_no_grant_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cpu_gnt_n && (&ext_gnt_n)));

    a_r5_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (($past(req) & gnt) != '0));

    a_r6_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ((req & gnt) == '0)) |=> (gnt == '0));

    a_r7_switch_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ($past(gnt) != '0) && (gnt != $past(gnt))) |-> $past(bus_idle));

    a_r12_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt[0]) && $past(gat)) |-> $past(flush_req));
endmodule

bind bus_arbiter8 bus_arbiter8_chk #(.N_EXT(N_EXT), .NM(NM)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (arb_en),
    .bus_idle  (bus_idle),
    .gat       (gat_active),
    .flush_req (flush_req),
    .req       (req_vec),
    .gnt       (gnt_vec),
    .cpu_gnt_n (cpu_gnt_n),
    .ext_gnt_n (ext_gnt_n)
);

// File: tb/bus_arbiter8_tb_top.sv
module bus_arbiter8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_strap = 1'b1;
    logic       bus_idle = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic       flush_sel = 1'b0;
    logic       gat_mode = 1'b0;
    logic [1:0] int_req = 2'b00;
    logic [1:0] int_gnt;
    logic       cpu_req_n = 1'b1;
    logic       cpu_gnt_n;
    logic [4:0] ext_req_n = 5'h1f;
    logic [4:0] ext_gnt_n;
    logic [1:0] pt_req_n;
    logic [1:0] pt_gnt_n = 2'b11;

    always #4 clk = ~clk;

    bus_arbiter8 dut_i (
        .clk(clk), .rst_n(rst_n), .arb_strap(arb_strap), .bus_idle(bus_idle),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .flush_sel(flush_sel), .gat_mode(gat_mode),
        .int_req(int_req), .int_gnt(int_gnt),
        .cpu_req_n(cpu_req_n), .cpu_gnt_n(cpu_gnt_n),
        .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n),
        .pt_req_n(pt_req_n), .pt_gnt_n(pt_gnt_n)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R4";

    // reference state, built from the requirements
    bit       m_en;
    bit       m_own;
    int       m_owner;
    int       m_last;
    bit [7:0] m_served;
    bit [7:0] m_hp;
    int       m_fg;

    function automatic bit m_flush();
        return m_en && flush_sel;
    endfunction

    function automatic bit [7:0] m_req();
        bit [7:0] r;
        bit gat;
        gat  = m_flush() && gat_mode;
        r[0] = gat ? ((m_fg == 2) && int_req[0]) : int_req[0];
        r[1] = int_req[1];
        r[2] = !cpu_req_n;
        for (int i = 0; i < 5; i++) r[3+i] = !ext_req_n[i];
        if (m_flush()) r[7] = 1'b0;
        return r;
    endfunction

    function automatic int next_from(bit [7:0] c, int from);
        for (int k = 1; k <= 8; k++) begin
            if (c[(from + k) % 8]) return (from + k) % 8;
        end
        return from;
    endfunction

    task automatic m_choose(bit [7:0] r);
        bit [7:0] elig, kept, h;
        int w;
        elig = r & ~m_served;
        kept = m_served;
        if (elig == 8'h00) begin
            elig = r;
            kept = 8'h00;
        end
        h = elig & m_hp;
        w = next_from((h != 8'h00) ? h : elig, m_last);
        m_own    = 1'b1;
        m_owner  = w;
        m_last   = w;
        m_served = kept | (8'h01 << w);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = arb_strap; m_own = 1'b0; m_owner = 0; m_last = 7;
            m_served = 8'h00; m_hp = 8'h00; m_fg = 0;
        end else begin
            bit [7:0] r;
            bit ack, gat;
            r   = m_req();
            gat = m_flush() && gat_mode;
            ack = !ext_req_n[4];
            if (m_en) begin
                if (!m_own) begin
                    if (r != 8'h00) m_choose(r);
                end else if (!r[m_owner]) begin
                    m_own = 1'b0;
                end else if (bus_idle && ((r & ~(8'h01 << m_owner)) != 8'h00)) begin
                    m_choose(r);
                end
            end
            if (!gat) m_fg = 0;
            else if (m_fg == 0) begin if (int_req[0]) m_fg = 1; end
            else if (m_fg == 1) begin if (!int_req[0]) m_fg = 0; else if (ack) m_fg = 2; end
            else begin if (!int_req[0]) m_fg = 0; end
            if (cfg_we && cfg_addr == 8'h80) m_hp = cfg_wdata;
        end
    end

    task automatic check_outputs();
        bit [7:0] g;
        logic [9:0] exp_v, act_v;
        logic [1:0] e_int, e_pt;
        logic [4:0] e_ext;
        g = m_own ? (8'h01 << m_owner) : 8'h00;
        e_int = m_en ? g[1:0] : ~pt_gnt_n;
        e_pt  = m_en ? 2'b11 : ~int_req;
        for (int i = 0; i < 4; i++) e_ext[i] = ~g[3+i];
        e_ext[4] = m_flush() ? ~(m_fg != 0) : ~g[7];
        exp_v = {e_int, ~g[2], e_ext, e_pt};
        act_v = {int_gnt, cpu_gnt_n, ext_gnt_n, pt_req_n};
        n_vec++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: {int_gnt,cpu_gnt_n,ext_gnt_n,pt_req_n} actual %b expected %b",
                     tag, act_v, exp_v);
        end
    endtask

    // one cycle: compare at the falling edge, then drive
    task automatic step();
        @(negedge clk);
        check_outputs();
        cfg_we = 1'b0;
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst_n = 1'b0; arb_strap = strap;
        int_req = 2'b00; cpu_req_n = 1'b1; ext_req_n = 5'h1f;
        flush_sel = 1'b0; gat_mode = 1'b0; bus_idle = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        arb_strap = ~strap;  // R1: later strap changes must not matter
    endtask

    task automatic random_cycles(int n, bit use_flush);
        for (int c = 0; c < n; c++) begin
            step();
            if ($urandom_range(5) == 0) int_req[0] = ~int_req[0];
            if ($urandom_range(5) == 0) int_req[1] = ~int_req[1];
            if ($urandom_range(5) == 0) cpu_req_n = ~cpu_req_n;
            for (int i = 0; i < 5; i++) if ($urandom_range(5) == 0) ext_req_n[i] = ~ext_req_n[i];
            bus_idle = ($urandom_range(2) == 0);
            pt_gnt_n = 2'($urandom_range(3));
            if ($urandom_range(40) == 0) begin
                cfg_we = 1'b1;
                cfg_addr = ($urandom_range(1) == 0) ? 8'h80 : 8'h81;
                cfg_wdata = 8'($urandom_range(255));
            end
            if (use_flush && $urandom_range(300) == 0) begin
                flush_sel = ~flush_sel; gat_mode = $urandom_range(1) == 1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4711));

        // R1 R4: reset state with strap high
        do_reset(1'b1);
        tag = "R1";
        step();
        tag = "R4";
        step();

        // R8 R5: three steady requesters on an idle bus rotate 2,3,5
        tag = "R8";
        cpu_req_n = 1'b0; ext_req_n = 5'b11010; bus_idle = 1'b1;
        repeat (8) step();

        // R6: owner holds while bus busy, then drops
        tag = "R6";
        bus_idle = 1'b0;
        repeat (4) step();
        cpu_req_n = 1'b1; ext_req_n = 5'h1f;
        repeat (3) step();

        // R9: write to wrong index ignored, then priority to master 5
        tag = "R9";
        cfg_we = 1'b1; cfg_addr = 8'h81; cfg_wdata = 8'h20;
        step();
        cpu_req_n = 1'b0; ext_req_n = 5'b11010; bus_idle = 1'b1;
        repeat (6) step();
        cfg_we = 1'b1; cfg_addr = 8'h80; cfg_wdata = 8'h20;
        step();
        // R10: high-priority master 5 still waits for the round to finish
        tag = "R10";
        repeat (10) step();
        cpu_req_n = 1'b1; ext_req_n = 5'h1f; bus_idle = 1'b0;
        repeat (2) step();

        // R11 R12: flush handshake before the bridge competes
        tag = "R11";
        flush_sel = 1'b1; gat_mode = 1'b1;
        ext_req_n[4] = 1'b1;
        step();
        tag = "R12";
        int_req[0] = 1'b1;
        repeat (5) step();
        ext_req_n[4] = 1'b0;
        repeat (4) step();
        int_req[0] = 1'b0; ext_req_n[4] = 1'b1;
        repeat (3) step();

        // R13: bridge without guaranteed access
        tag = "R13";
        gat_mode = 1'b0;
        int_req[0] = 1'b1;
        repeat (3) step();
        int_req[0] = 1'b0;
        repeat (2) step();
        flush_sel = 1'b0;

        // R4 R5 R7 R9 R10 R11: constrained random
        tag = "R7";
        random_cycles(4000, 1'b1);

        // R1 R2: strap low gives pass-through, flush_sel ignored
        do_reset(1'b0);
        tag = "R2";
        flush_sel = 1'b1; gat_mode = 1'b1;
        random_cycles(800, 1'b0);

        // R1 R3: strap high again
        do_reset(1'b1);
        tag = "R3";
        random_cycles(1500, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule